// File: doc/BRIEF.md
# Prescaled Clock Divider with Truncation-Free Output Gating

This block turns one reference clock into two clocks. The first is a master clock: the reference passed straight through, or divided by two or by four. The second is a divided clock: the master clock divided by a 9-bit programmable divisor. There is also a divide-by-one path that sends the raw reference straight to the output. The divider, bypass and prescaler settings are sampled only while reset is held. After that they stay fixed until the next reset.

An output-enable input can stop and restart the divided clock at any time. The enable passes through a two-stage synchronizer that is clocked on master-clock rising edges. On disable, a high pulse already on the output always runs to its full width, and no new pulse starts after that. While the output is stopped the divider counter stays at zero, so on release the output has a fixed phase relative to the enable. The master clock output is never gated.

Top module: `gated_clock_divider`

## Requirements
- R1: With the divide-by-one bit clear, the divided clock has a period of P*(code+2) reference cycles. Here code is the 9-bit divider field (0..511, so the divisor N runs from 2 to 513) and P is the prescale ratio.
- R2: With the divide-by-one bit clear, each divided-clock high phase lasts floor(N/2)*P reference cycles, and the low phase lasts for the rest of the period.
- R3: When the divide-by-one, bypass and external-reference bits are all 0, the prescale select chooses the ratio: select=1 gives P=2 and select=0 gives P=4. The master clock output is then a square wave of P reference cycles, high for the first P/2.
- R4: When the bypass bit or the external-reference bit (or the divide-by-one bit) is 1, then P=1 and the master clock output follows the reference clock.
- R5: With the divide-by-one bit set and the output enabled, the divided clock equals the reference clock. The divider field and the prescaler bits then have no effect.
- R6: The configuration inputs are sampled only while rstN is low. Changing them after reset does not change either output.
- R7: Outside divide-by-one mode, no divided-clock high pulse is ever shorter than its nominal width. Once a low enable has passed the synchronizer, no new rising edge appears.
- R8: Outside divide-by-one mode, the enable is sampled by two flops on master rising edges. The output therefore first rises on the third master rising edge after the enable goes high.
- R9: While disabled, the divider counter is held at zero. After release, the first output period is complete: a full high phase followed by a full low phase.
- R10: While rstN is low, the divided clock is low. The master clock output is also low when P is 2 or 4.
- R11: In divide-by-one mode the gate changes only while the reference is low, so no partial pulse appears. If the enable falls during a low half, exactly two more full pulses follow before the output stays low. On re-enable, the output rises on the third reference rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low reset; configuration is sampled while low |
| cfgDivCode | input | 9 | Divider field; divisor is the field plus two |
| cfgDivOne | input | 1 | 1 sends the raw reference to the divided output |
| cfgPreBypass | input | 1 | 1 skips the prescaler |
| cfgPreHalf | input | 1 | Prescale ratio select: 1 gives /2, 0 gives /4 |
| cfgExtRef | input | 1 | External-reference flag; 1 skips the prescaler |
| outEnable | input | 1 | Synchronous output enable for the divided clock |
| divClkOut | output | 1 | Divided, gated output clock |
| masterClkOut | output | 1 | Prescaled master clock |

## Verification
The divider is exercised with a table of settings that covers the smallest even and odd divisors, the largest divisor, both prescale ratios, the external flag overriding a /4 select, and divide-by-one with two different field values. Together these separate an off-by-one in the field offset, a wrong duty split for odd divisors, a swapped prescale encoding and a missing bypass. Directed sequences raise and drop the enable at known phases. They separate a synchronizer of the wrong depth, a counter that is not cleared while stopped, and a stop that cuts a pulse short. A long run of random enable toggles checks every high pulse against its nominal width.

// File: rtl/gcd_pkg.sv
`timescale 1ns/1ps
package gcd_pkg;

  // Strobes issued by the control to the datapath on a master rising edge
  typedef struct packed {
    logic start;   // begin a fresh output period, output goes high
    logic stop;    // park the divider: counter to zero, output low
    logic step;    // advance the divider by one master period
  } gcdStrobe_t;

  // Datapath state reported back to the control
  typedef struct packed {
    logic mRise;      // the coming reference edge is a master rising edge
    logic periodEnd;  // divider is in the last master period of its cycle
    logic running;    // divider is producing pulses
  } gcdStatus_t;

endpackage

// File: rtl/gcd_ctrl.sv
`timescale 1ns/1ps
module gcd_ctrl
  import gcd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       refClk,
  input  logic       rstN,
  input  logic       outEnable,
  input  gcdStatus_t status,
  output gcdStrobe_t stb,
  output logic       enSync
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   wrapPoint;

  // Enable synchronizer advanced only on master rising edges
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
    end else if (status.mRise) begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], outEnable};
    end
  end

  assign enSync = syncQ[SYNC_STAGES-1];

  // A new period may begin only when stopped or at the end of a period
  assign wrapPoint = status.mRise && (!status.running || status.periodEnd);

  always_comb begin
    stb.start = wrapPoint && enSync;
    stb.stop  = wrapPoint && !enSync && status.running;
    stb.step  = status.mRise && status.running && !status.periodEnd;
  end

  // R7: at most one divider action per master edge
  assert_strobe_onehot_R7: assert property (@(posedge refClk) disable iff (!rstN)
    $onehot0({stb.start, stb.stop, stb.step}));

endmodule

// File: rtl/gcd_datapath.sv
`timescale 1ns/1ps
module gcd_datapath
  import gcd_pkg::*;
#(
  parameter int DIV_W      = 9,
  parameter int DIV_OFFSET = 2
) (
  input  logic             refClk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] cfgDivCode,
  input  logic             cfgDivOne,
  input  logic             cfgPreBypass,
  input  logic             cfgPreHalf,
  input  logic             cfgExtRef,
  input  gcdStrobe_t       stb,
  input  logic             enSync,
  output gcdStatus_t       status,
  output logic             divClkOut,
  output logic             masterClkOut
);

  localparam int CNT_W = $clog2((2 ** DIV_W) + DIV_OFFSET);
  localparam int PRE_W = 2;   // counter for ratios up to 4

  // Configuration registers, loaded only while reset is held
  logic [DIV_W-1:0] codeQ;
  logic             divOneQ, bypassQ, halfQ, extQ;

  always_ff @(posedge refClk) begin
    if (!rstN) begin
      codeQ   <= cfgDivCode;
      divOneQ <= cfgDivOne;
      bypassQ <= cfgPreBypass;
      halfQ   <= cfgPreHalf;
      extQ    <= cfgExtRef;
    end
  end

  logic [CNT_W-1:0] divisor, hiLen;
  logic [PRE_W:0]   preRatio;

  assign divisor  = CNT_W'(codeQ) + CNT_W'(DIV_OFFSET);
  assign hiLen    = divisor >> 1;
  assign preRatio = (divOneQ || extQ || bypassQ) ? 3'd1 : (halfQ ? 3'd2 : 3'd4);

  // Prescaler: counts reference cycles inside one master period
  logic [PRE_W-1:0] preCnt, preNext;
  logic             mRise, mclkQ;

  assign mRise   = ({1'b0, preCnt} == (preRatio - 3'd1));
  assign preNext = mRise ? '0 : preCnt + 2'd1;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '1;
      mclkQ  <= 1'b0;
    end else begin
      preCnt <= preNext;
      mclkQ  <= ({1'b0, preNext} < (preRatio >> 1));
    end
  end

  // Programmable divider in master periods
  logic [CNT_W-1:0] divCnt;
  logic             divQ, running;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      divCnt  <= '0;
      divQ    <= 1'b0;
      running <= 1'b0;
    end else if (stb.start) begin
      divCnt  <= '0;
      divQ    <= 1'b1;
      running <= 1'b1;
    end else if (stb.stop) begin
      divCnt  <= '0;
      divQ    <= 1'b0;
      running <= 1'b0;
    end else if (stb.step) begin
      divCnt  <= divCnt + CNT_W'(1);
      divQ    <= (divCnt + CNT_W'(1)) < hiLen;
    end
  end

  always_comb begin
    status.mRise     = mRise;
    status.periodEnd = (divCnt == divisor - CNT_W'(1));
    status.running   = running;
  end

  // Divide-by-one gate: updated only while the reference is low
  logic gateQ;

  always_ff @(negedge refClk or negedge rstN) begin
    if (!rstN) gateQ <= 1'b0;
    else       gateQ <= enSync;
  end

  assign divClkOut    = divOneQ ? (refClk & gateQ) : divQ;
  assign masterClkOut = (preRatio == 3'd1) ? refClk : mclkQ;

  // R1: divider index stays inside the programmed divisor
  assert_cnt_in_range_R1: assert property (@(posedge refClk) disable iff (!rstN)
    divCnt < divisor);

  // R2: the output falls only after the full high span has elapsed
  assert_pulse_full_R2: assert property (@(posedge refClk) disable iff (!rstN)
    $fell(divQ) |-> ($past(divCnt) == hiLen - CNT_W'(1)));

  // R3: master clock rises only at the start of a prescale period
  assert_prescale_phase_R3: assert property (@(posedge refClk) disable iff (!rstN)
    $rose(mclkQ) |-> (preCnt == '0));

  // R9: a stopped divider sits at zero with its output low
  assert_hold_while_off_R9: assert property (@(posedge refClk) disable iff (!rstN)
    !running |-> (divCnt == '0 && !divQ));

endmodule

// File: rtl/gated_clock_divider.sv
`timescale 1ns/1ps
module gated_clock_divider
  import gcd_pkg::*;
#(
  parameter int DIV_W       = 9,
  parameter int DIV_OFFSET  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             refClk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] cfgDivCode,
  input  logic             cfgDivOne,
  input  logic             cfgPreBypass,
  input  logic             cfgPreHalf,
  input  logic             cfgExtRef,
  input  logic             outEnable,
  output logic             divClkOut,
  output logic             masterClkOut
);

  gcdStrobe_t stb;
  gcdStatus_t status;
  logic       enSync;

  gcd_ctrl #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .refClk   (refClk),
    .rstN     (rstN),
    .outEnable(outEnable),
    .status   (status),
    .stb      (stb),
    .enSync   (enSync)
  );

  gcd_datapath #(
    .DIV_W     (DIV_W),
    .DIV_OFFSET(DIV_OFFSET)
  ) u_datapath (
    .refClk      (refClk),
    .rstN        (rstN),
    .cfgDivCode  (cfgDivCode),
    .cfgDivOne   (cfgDivOne),
    .cfgPreBypass(cfgPreBypass),
    .cfgPreHalf  (cfgPreHalf),
    .cfgExtRef   (cfgExtRef),
    .stb         (stb),
    .enSync      (enSync),
    .status      (status),
    .divClkOut   (divClkOut),
    .masterClkOut(masterClkOut)
  );

endmodule

// File: tb/test_gated_clock_divider.sv
`timescale 1ns/1ps
module test_gated_clock_divider;

  logic       refClk = 1'b0;
  logic       rstN = 1'b0;
  logic [8:0] cfgDivCode = '0;
  logic       cfgDivOne = 1'b0;
  logic       cfgPreBypass = 1'b1;
  logic       cfgPreHalf = 1'b0;
  logic       cfgExtRef = 1'b0;
  logic       outEnable = 1'b0;
  logic       divClkOut, masterClkOut;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  // 250 MHz: 4 ns period, one half period = 2 ns
  always #2 refClk = ~refClk;

  gated_clock_divider i_gated_clock_divider (
    .refClk      (refClk),
    .rstN        (rstN),
    .cfgDivCode  (cfgDivCode),
    .cfgDivOne   (cfgDivOne),
    .cfgPreBypass(cfgPreBypass),
    .cfgPreHalf  (cfgPreHalf),
    .cfgExtRef   (cfgExtRef),
    .outEnable   (outEnable),
    .divClkOut   (divClkOut),
    .masterClkOut(masterClkOut)
  );

  // Settings and expected periods in half reference cycles (2 ns units)
  typedef struct packed {
    logic [8:0] code;
    logic       one;
    logic       byp;
    logic       half;
    logic       ext;
    int         perH;
    int         hiH;
    int         mPerH;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{9'd0,   1'b0, 1'b1, 1'b0, 1'b0, 4,    2,   2},  // N=2 P=1
    '{9'd1,   1'b0, 1'b1, 1'b0, 1'b0, 6,    2,   2},  // N=3 P=1
    '{9'd511, 1'b0, 1'b1, 1'b0, 1'b0, 1026, 512, 2},  // N=513 P=1
    '{9'd0,   1'b0, 1'b0, 1'b1, 1'b0, 8,    4,   4},  // N=2 P=2
    '{9'd0,   1'b0, 1'b0, 1'b0, 1'b0, 16,   8,   8},  // N=2 P=4
    '{9'd1,   1'b0, 1'b0, 1'b0, 1'b0, 24,   8,   8},  // N=3 P=4
    '{9'd3,   1'b0, 1'b0, 1'b0, 1'b1, 10,   4,   2},  // ext: N=5 P=1
    '{9'd5,   1'b0, 1'b0, 1'b1, 1'b0, 28,   12,  4},  // N=7 P=2
    '{9'd37,  1'b1, 1'b0, 1'b0, 1'b0, 2,    1,   2},  // divide-by-one
    '{9'd100, 1'b1, 1'b0, 1'b1, 1'b1, 2,    1,   2}   // divide-by-one
  };

  // Pulse monitor on the divided clock
  int      riseCount = 0;
  int      badPulse = 0;
  bit      monOn = 1'b0;
  realtime expHiNs = 0.0;
  realtime tRise = 0.0;

  always @(posedge divClkOut) begin
    riseCount++;
    tRise = $realtime;
  end

  always @(negedge divClkOut) begin
    if (monOn) begin
      realtime w;
      w = $realtime - tRise;
      if (w < expHiNs - 0.1 || w > expHiNs + 0.1) badPulse++;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic atLow();
    @(negedge refClk);
    #1;
  endtask

  task automatic afterRise();
    @(posedge refClk);
    #1;
  endtask

  task automatic applyCfg(input vec_t v, input logic oe);
    atLow();
    rstN = 1'b0;
    cfgDivCode = v.code;
    cfgDivOne = v.one;
    cfgPreBypass = v.byp;
    cfgPreHalf = v.half;
    cfgExtRef = v.ext;
    outEnable = oe;
    repeat (4) atLow();
    rstN = 1'b1;
  endtask

  task automatic measureDiv(output int perH, output int hiH);
    realtime t0, t1, t2;
    @(posedge divClkOut); t0 = $realtime;
    @(negedge divClkOut); t1 = $realtime;
    @(posedge divClkOut); t2 = $realtime;
    perH = int'((t2 - t0) / 2.0);
    hiH  = int'((t1 - t0) / 2.0);
  endtask

  task automatic measureMaster(output int perH, output int hiH);
    realtime t0, t1, t2;
    @(posedge masterClkOut); t0 = $realtime;
    @(negedge masterClkOut); t1 = $realtime;
    @(posedge masterClkOut); t2 = $realtime;
    perH = int'((t2 - t0) / 2.0);
    hiH  = int'((t1 - t0) / 2.0);
  endtask

  initial begin
    int p, h, snap;

    // R10: reset state with a /4 setting
    applyCfg(VECS[4], 1'b1);
    atLow();
    rstN = 1'b0;
    repeat (3) atLow();
    check("R10 divClkOut low in reset", int'(divClkOut), 0);
    check("R10 masterClkOut low in reset (P=4)", int'(masterClkOut), 0);
    afterRise();
    check("R10 divClkOut low in reset after edge", int'(divClkOut), 0);
    check("R10 masterClkOut low in reset after edge", int'(masterClkOut), 0);

    // Table walk: R1 R2 R3 R4 R5
    for (int i = 0; i < NVEC; i++) begin
      applyCfg(VECS[i], 1'b1);
      repeat (10) atLow();
      measureDiv(p, h);
      check($sformatf("R1/R5 vec%0d divided period", i), p, VECS[i].perH);
      check($sformatf("R2/R5 vec%0d divided high", i), h, VECS[i].hiH);
      measureMaster(p, h);
      check($sformatf("R3/R4 vec%0d master period", i), p, VECS[i].mPerH);
      check($sformatf("R3/R4 vec%0d master high", i), h, VECS[i].mPerH / 2);
    end

    // R6: changing configuration after reset has no effect
    applyCfg(VECS[0], 1'b1);
    repeat (5) atLow();
    cfgDivCode = 9'd511;
    cfgPreBypass = 1'b0;
    cfgPreHalf = 1'b0;
    cfgDivOne = 1'b1;
    repeat (5) atLow();
    measureDiv(p, h);
    check("R6 period after late config change", p, 4);
    measureMaster(p, h);
    check("R6 master period after late config change", p, 2);

    // R8: release latency, N=4 P=1
    applyCfg('{9'd2, 1'b0, 1'b1, 1'b0, 1'b0, 0, 0, 0}, 1'b0);
    repeat (20) atLow();
    check("R8 output idle while disabled", riseCount > 0 ? int'(divClkOut) : 0, 0);
    snap = riseCount;
    repeat (10) atLow();
    check("R8 no pulses while disabled", riseCount - snap, 0);
    outEnable = 1'b1;
    afterRise();
    afterRise();
    check("R8 low after second edge", int'(divClkOut), 0);
    afterRise();
    check("R8 high on third edge", int'(divClkOut), 1);

    // R9: stop mid-period, re-enable, first period complete from its start
    repeat (5) atLow();
    outEnable = 1'b0;
    repeat (30) atLow();
    outEnable = 1'b1;
    afterRise();
    afterRise();
    check("R9 low after second edge", int'(divClkOut), 0);
    afterRise();
    check("R9 high on third edge", int'(divClkOut), 1);
    afterRise();
    check("R9 still high at fourth edge", int'(divClkOut), 1);
    afterRise();
    check("R9 low at fifth edge", int'(divClkOut), 0);

    // R7: random enable toggles, N=7 P=2, high must be 24 ns
    applyCfg(VECS[7], 1'b1);
    expHiNs = 24.0;
    badPulse = 0;
    monOn = 1'b1;
    for (int k = 0; k < 40; k++) begin
      repeat ($urandom_range(40, 1)) atLow();
      outEnable = ~outEnable;
    end
    outEnable = 1'b1;
    repeat (40) atLow();
    // R7: drop enable while output is high
    @(posedge divClkOut);
    #3;
    outEnable = 1'b0;
    snap = riseCount;
    repeat (100) atLow();
    check("R7 no new rise after disable", riseCount - snap, 0);
    check("R7 output low after disable", int'(divClkOut), 0);
    monOn = 1'b0;
    check("R7 short pulses during toggles", badPulse, 0);

    // R11: divide-by-one gating
    applyCfg(VECS[8], 1'b1);
    expHiNs = 2.0;
    badPulse = 0;
    repeat (10) atLow();
    monOn = 1'b1;
    snap = riseCount;
    outEnable = 1'b0;
    repeat (20) atLow();
    check("R11 extra pulses after disable", riseCount - snap, 2);
    afterRise();
    check("R11 low while disabled", int'(divClkOut), 0);
    atLow();
    outEnable = 1'b1;
    afterRise();
    check("R11 low after first edge", int'(divClkOut), 0);
    afterRise();
    check("R11 low after second edge", int'(divClkOut), 0);
    afterRise();
    check("R11 high on third edge", int'(divClkOut), 1);
    repeat (10) atLow();
    monOn = 1'b0;
    check("R11 no partial pulses", badPulse, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge refClk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule